// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at each instruction boundary in user mode, whether execution leaves the user program, and carries out the entry. It watches three hardware sources (timer, disk, console), a software-interrupt request with its number, and an exception request. When it takes one, it computes the handler address from an internal constant vector table and switches to privileged mode. For every interrupt it also issues a single stack write that saves the return address at the incremented stack pointer. The vector table holds 19 entries, numbered 0 to 18. Entry 0 is the exception handler. Entries 1 to 3 are the timer, disk and console. Entries 4 to 18 are software interrupts.

The stack push is range-checked against the page-table length. When the push would fall outside the process's logical space, no write is made and the entry becomes an illegal-memory-access exception. A hardware source whose entry failed this way stays pending and is served again at the first boundary after the next return to user mode. The sequencer stays privileged, and ignores boundaries, until the return-from-interrupt input is pulsed. Address translation, memory and handler execution belong to the surrounding processor.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is in user mode and `ent_valid_o`, `mem_we_o` and `exc_valid_o` are 0.
- R2: The handler address for number n is VEC_STRIDE*(n+1). With the defaults, numbers 0, 1, 2 and 3 map to 1024, 2048, 3072 and 4096, and number 18 maps to 19456.
- R3: An interrupt entry writes one word at address SP+1 and reports SP+1 on `new_sp_o`. Arithmetic is modulo 2^DATA_W, so SP = all-ones pushes at address 0.
- R4: A hardware entry pushes the current IP. A software entry pushes IP+2.
- R5: A push is legal only when SP+1 < PTLR*PAGE_WORDS. Otherwise there is no write, and the block takes exception entry with `exc_code_o`=2, `exc_addr_o`=SP+1, `new_sp_o`=SP and `new_ip_o` = the vector for number 0.
- R6: A hardware source whose push failed stays pending. It is taken at the next user-mode boundary.
- R7: At most one source is served per boundary. Pending hardware sources are served timer first, then disk, then console. On `irq_raise_i`, bit 0 is the timer, bit 1 the disk and bit 2 the console.
- R8: An exception request has precedence over any interrupt at the same boundary. It jumps to vector 0 with no push, and `exc_code_o` carries `exc_cause_i`. The 2-bit cause codes are 0 page fault, 1 illegal instruction, 2 illegal memory access and 3 arithmetic. Hardware sources pending at that boundary stay pending.
- R9: A software request whose number lies outside 4..18 becomes exception entry with code 1 and no push.
- R10: Once an entry is taken, the block is privileged (`priv_o`=1) and ignores boundaries until `iret_i` returns it to user mode.
- R11: A software request at a boundary is served before any pending hardware source. The hardware source stays pending.
- R12: Outputs are registered. They change in the cycle after the boundary, and `ent_valid_o` is high for exactly one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | A user instruction has completed |
| iret_i | input | 1 | Return from handler to user mode |
| irq_raise_i | input | NUM_HW | Hardware event strobes (bit0 timer, bit1 disk, bit2 console) |
| swi_req_i | input | 1 | Software interrupt instruction at this boundary |
| swi_num_i | input | NUM_W | Software interrupt number |
| exc_req_i | input | 1 | Exception raised by the completing instruction |
| exc_cause_i | input | 2 | Cause code of that exception |
| ip_i | input | DATA_W | Current instruction pointer |
| sp_i | input | DATA_W | Current stack pointer |
| ptlr_i | input | PTLR_W | Page-table length in pages |
| ent_valid_o | output | 1 | One-cycle pulse: an entry was taken |
| new_ip_o | output | DATA_W | Handler address |
| new_sp_o | output | DATA_W | Stack pointer after entry |
| priv_o | output | 1 | Privileged mode |
| mem_we_o | output | 1 | Stack write strobe |
| mem_addr_o | output | DATA_W | Stack write logical address |
| mem_data_o | output | DATA_W | Stack write data |
| exc_valid_o | output | 1 | The entry went to the exception vector |
| exc_code_o | output | 2 | Exception cause code |
| exc_addr_o | output | DATA_W | Faulting address for code 2 |

## Verification
The bench builds the block with PTLR_W=3 and PAGE_WORDS=16. A page-table length of 2 then gives a stack limit of 32, so both sides of the push bound can be reached with small stack values (SP=30 passes, SP=31 faults). A length of 0 forces a fault on any push, and SP=all-ones checks the wrap to address 0. DATA_W and VEC_STRIDE keep their defaults, so the handler addresses seen are the real 1024-stride values, up to 19456 for number 18.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam logic [1:0] CAUSE_PAGE  = 2'd0;
  localparam logic [1:0] CAUSE_ILLEG = 2'd1;
  localparam logic [1:0] CAUSE_MEM   = 2'd2;
  localparam logic [1:0] CAUSE_ARITH = 2'd3;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_EXC  = 2'd1,
    PICK_SWI  = 2'd2,
    PICK_HW   = 2'd3
  } pick_e;
endpackage

// File: rtl/irq_vec_rom.sv
module irq_vec_rom #(
  parameter int DATA_W     = 16,
  parameter int NUM_VEC    = 19,
  parameter int VEC_STRIDE = 1024,
  localparam int NUM_W     = $clog2(NUM_VEC)
) (
  input  logic [NUM_W-1:0]  idx_i,
  output logic [DATA_W-1:0] addr_o
);
  logic [DATA_W-1:0] rom [NUM_VEC];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    assign rom[g] = DATA_W'(VEC_STRIDE * (g + 1));
  end

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (idx_i == NUM_W'(i)) addr_o = rom[i];
    end
  end
endmodule

// File: rtl/irq_hw_arb.sv
module irq_hw_arb #(
  parameter int NUM_HW = 3,
  localparam int IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_HW-1:0] raise_i,
  input  logic              serve_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [NUM_HW-1:0] pend_q;
  logic [NUM_HW-1:0] grant;

  always_comb begin
    grant = '0;
    idx_o = '0;
    for (int i = NUM_HW - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o = |pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~(grant & {NUM_HW{serve_i}})) | raise_i;
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_serve_pending_R6: assert property (@(posedge clk) disable iff (rst)
    serve_i |-> any_o);
endmodule

// File: rtl/irq_stack_chk.sv
module irq_stack_chk #(
  parameter int DATA_W     = 16,
  parameter int PTLR_W     = 6,
  parameter int PAGE_WORDS = 512,
  localparam int PG_BITS   = $clog2(PAGE_WORDS),
  localparam int CMP_W     = ((DATA_W > PTLR_W + PG_BITS) ? DATA_W : PTLR_W + PG_BITS) + 1
) (
  input  logic [DATA_W-1:0] sp_i,
  input  logic [PTLR_W-1:0] ptlr_i,
  output logic [DATA_W-1:0] sp_inc_o,
  output logic              ok_o
);
  logic [CMP_W-1:0] limit;

  assign sp_inc_o = sp_i + DATA_W'(1);
  assign limit    = CMP_W'(ptlr_i) << PG_BITS;
  assign ok_o     = CMP_W'(sp_inc_o) < limit;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PTLR_W     = 6,
  parameter int PAGE_WORDS = 512,
  parameter int VEC_STRIDE = 1024,
  parameter int NUM_VEC    = 19,
  parameter int NUM_HW     = 3,
  parameter int SWI_FIRST  = 4,
  localparam int NUM_W     = $clog2(NUM_VEC),
  localparam int HW_IDX_W  = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              iret_i,
  input  logic [NUM_HW-1:0] irq_raise_i,
  input  logic              swi_req_i,
  input  logic [NUM_W-1:0]  swi_num_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_cause_i,
  input  logic [DATA_W-1:0] ip_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [PTLR_W-1:0] ptlr_i,
  output logic              ent_valid_o,
  output logic [DATA_W-1:0] new_ip_o,
  output logic [DATA_W-1:0] new_sp_o,
  output logic              priv_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              exc_valid_o,
  output logic [1:0]        exc_code_o,
  output logic [DATA_W-1:0] exc_addr_o
);
  logic              priv_q;
  logic              hw_any;
  logic [HW_IDX_W-1:0] hw_idx;
  logic              hw_serve;
  logic [DATA_W-1:0] sp_inc;
  logic              push_ok;
  logic [NUM_W-1:0]  vidx;
  logic [DATA_W-1:0] vaddr;
  logic              swi_legal;

  pick_e             pick;
  logic              take, push, to_exc;
  logic [1:0]        code;
  logic [DATA_W-1:0] push_data, fault_addr;

  irq_hw_arb #(.NUM_HW(NUM_HW)) u_arb (
    .clk(clk), .rst(rst), .raise_i(irq_raise_i), .serve_i(hw_serve),
    .any_o(hw_any), .idx_o(hw_idx)
  );

  irq_stack_chk #(.DATA_W(DATA_W), .PTLR_W(PTLR_W), .PAGE_WORDS(PAGE_WORDS)) u_chk (
    .sp_i(sp_i), .ptlr_i(ptlr_i), .sp_inc_o(sp_inc), .ok_o(push_ok)
  );

  irq_vec_rom #(.DATA_W(DATA_W), .NUM_VEC(NUM_VEC), .VEC_STRIDE(VEC_STRIDE)) u_rom (
    .idx_i(vidx), .addr_o(vaddr)
  );

  assign swi_legal = (swi_num_i >= NUM_W'(SWI_FIRST)) && (swi_num_i <= NUM_W'(NUM_VEC - 1));

  always_comb begin
    pick = PICK_NONE;
    if (boundary_i && !priv_q) begin
      if (exc_req_i)      pick = PICK_EXC;
      else if (swi_req_i) pick = PICK_SWI;
      else if (hw_any)    pick = PICK_HW;
    end
  end

  always_comb begin
    take       = (pick != PICK_NONE);
    push       = 1'b0;
    to_exc     = 1'b0;
    code       = CAUSE_PAGE;
    vidx       = '0;
    push_data  = ip_i;
    fault_addr = '0;
    hw_serve   = 1'b0;
    case (pick)
      PICK_EXC: begin
        to_exc = 1'b1;
        code   = exc_cause_i;
      end
      PICK_SWI: begin
        if (!swi_legal) begin
          to_exc = 1'b1;
          code   = CAUSE_ILLEG;
        end else if (!push_ok) begin
          to_exc     = 1'b1;
          code       = CAUSE_MEM;
          fault_addr = sp_inc;
        end else begin
          push      = 1'b1;
          vidx      = swi_num_i;
          push_data = ip_i + DATA_W'(2);
        end
      end
      PICK_HW: begin
        if (!push_ok) begin
          to_exc     = 1'b1;
          code       = CAUSE_MEM;
          fault_addr = sp_inc;
        end else begin
          push     = 1'b1;
          hw_serve = 1'b1;
          vidx     = NUM_W'(hw_idx) + NUM_W'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q      <= 1'b0;
      ent_valid_o <= 1'b0;
      new_ip_o    <= '0;
      new_sp_o    <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      exc_valid_o <= 1'b0;
      exc_code_o  <= '0;
      exc_addr_o  <= '0;
    end else begin
      ent_valid_o <= take;
      mem_we_o    <= push;
      exc_valid_o <= to_exc;
      if (take) begin
        priv_q     <= 1'b1;
        new_ip_o   <= vaddr;
        new_sp_o   <= push ? sp_inc : sp_i;
        mem_addr_o <= sp_inc;
        mem_data_o <= push_data;
        exc_code_o <= code;
        exc_addr_o <= fault_addr;
      end else if (iret_i) begin
        priv_q <= 1'b0;
      end
    end
  end

  assign priv_o = priv_q;

  assert_entry_priv_R10: assert property (@(posedge clk) disable iff (rst)
    ent_valid_o |-> priv_o);

  assert_no_entry_priv_R10: assert property (@(posedge clk) disable iff (rst)
    (priv_o && !iret_i) |=> !ent_valid_o);

  assert_push_addr_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_addr_o == $past(sp_i) + DATA_W'(1)));

  assert_fault_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    exc_valid_o |-> !mem_we_o);

  assert_irq_pushes_R4: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_o && !exc_valid_o) |-> mem_we_o);

  assert_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    ent_valid_o |=> !ent_valid_o);
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary = 0, iret = 0, swi = 0, exc = 0;
  logic [2:0] raise = '0;
  logic [4:0] num = '0;
  logic [1:0] cause = '0;
  logic [DW-1:0] ip = '0, sp = '0;
  logic [2:0] ptlr = '0;
  logic ent_valid, priv, we, exc_valid;
  logic [DW-1:0] new_ip, new_sp, maddr, mdata, eaddr;
  logic [1:0] ecode;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_entry_seq #(.PTLR_W(3), .PAGE_WORDS(16)) u_irq_entry_seq (
    .clk(clk), .rst(rst), .boundary_i(boundary), .iret_i(iret),
    .irq_raise_i(raise), .swi_req_i(swi), .swi_num_i(num),
    .exc_req_i(exc), .exc_cause_i(cause), .ip_i(ip), .sp_i(sp), .ptlr_i(ptlr),
    .ent_valid_o(ent_valid), .new_ip_o(new_ip), .new_sp_o(new_sp), .priv_o(priv),
    .mem_we_o(we), .mem_addr_o(maddr), .mem_data_o(mdata),
    .exc_valid_o(exc_valid), .exc_code_o(ecode), .exc_addr_o(eaddr)
  );

  typedef struct packed {
    logic [4:0]  n;
    logic [15:0] ip;
    logic [15:0] sp;
    logic [2:0]  pt;
    logic [15:0] x_ip;
    logic [15:0] x_sp;
    logic        x_we;
    logic        x_exc;
    logic [1:0]  x_code;
    logic [15:0] x_ea;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{5'd4,  16'd100, 16'd10,     3'd2, 16'd5120,  16'd11, 1'b1, 1'b0, 2'd0, 16'd0},
    '{5'd18, 16'd200, 16'd30,     3'd2, 16'd19456, 16'd31, 1'b1, 1'b0, 2'd0, 16'd0},
    '{5'd7,  16'd300, 16'd31,     3'd2, 16'd1024,  16'd31, 1'b0, 1'b1, 2'd2, 16'd32},
    '{5'd3,  16'd40,  16'd5,      3'd2, 16'd1024,  16'd5,  1'b0, 1'b1, 2'd1, 16'd0},
    '{5'd19, 16'd44,  16'd6,      3'd2, 16'd1024,  16'd6,  1'b0, 1'b1, 2'd1, 16'd0},
    '{5'd9,  16'd500, 16'hFFFF,   3'd2, 16'd10240, 16'd0,  1'b1, 1'b0, 2'd0, 16'd0},
    '{5'd5,  16'd600, 16'd0,      3'd0, 16'd1024,  16'd0,  1'b0, 1'b1, 2'd2, 16'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bnd(input bit s, input logic [4:0] n, input bit e, input logic [1:0] c,
                     input logic [DW-1:0] i, input logic [DW-1:0] p, input logic [2:0] t);
    @(negedge clk);
    boundary = 1; swi = s; num = n; exc = e; cause = c; ip = i; sp = p; ptlr = t;
    @(negedge clk);
    boundary = 0; swi = 0; exc = 0;
  endtask

  task automatic do_iret();
    @(negedge clk); iret = 1;
    @(negedge clk); iret = 0;
  endtask

  task automatic do_raise(input logic [2:0] b);
    @(negedge clk); raise = b;
    @(negedge clk); raise = '0;
  endtask

  task automatic hw_entry(input string req, input int x_ip, input int i, input int p);
    bnd(0, 5'd0, 0, 2'd0, DW'(i), DW'(p), 3'd2);
    chk(ent_valid && !exc_valid, req, "entry taken", int'(ent_valid), 1);
    chk(new_ip == DW'(x_ip), req, "handler ip", int'(new_ip), x_ip);
    chk(we && mdata == DW'(i), req, "pushed ip (R4)", int'(mdata), i);
    chk(maddr == DW'(p + 1) && new_sp == DW'(p + 1), req, "push addr (R3)", int'(maddr), p + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(!priv && !ent_valid && !we && !exc_valid, "R1", "reset outputs",
        int'({priv, ent_valid, we, exc_valid}), 0);

    // table of software requests: R2 R3 R4 R5 R9
    for (int k = 0; k < NV; k++) begin
      bnd(1, TBL[k].n, 0, 2'd0, TBL[k].ip, TBL[k].sp, TBL[k].pt);
      chk(ent_valid, "R12", "entry pulse", int'(ent_valid), 1);
      chk(new_ip == TBL[k].x_ip, "R2", "vector", int'(new_ip), int'(TBL[k].x_ip));
      chk(new_sp == TBL[k].x_sp, "R3", "new sp", int'(new_sp), int'(TBL[k].x_sp));
      chk(we == TBL[k].x_we, "R5", "write strobe", int'(we), int'(TBL[k].x_we));
      chk(exc_valid == TBL[k].x_exc, "R9", "exception flag", int'(exc_valid), int'(TBL[k].x_exc));
      if (TBL[k].x_we) begin
        chk(mdata == TBL[k].ip + 16'd2, "R4", "swi push data", int'(mdata), int'(TBL[k].ip) + 2);
        chk(maddr == TBL[k].x_sp, "R3", "swi push addr", int'(maddr), int'(TBL[k].x_sp));
      end
      if (TBL[k].x_exc) chk(ecode == TBL[k].x_code, "R5", "cause", int'(ecode), int'(TBL[k].x_code));
      if (TBL[k].x_code == 2'd2) chk(eaddr == TBL[k].x_ea, "R5", "fault addr", int'(eaddr), int'(TBL[k].x_ea));
      do_iret();
      chk(!priv, "R10", "iret back to user", int'(priv), 0);
    end

    // R7 fixed order, one per boundary
    do_raise(3'b111);
    hw_entry("R7", 2048, 50, 1);
    @(negedge clk);
    chk(!ent_valid && !we, "R12", "pulse one cycle", int'(ent_valid), 0);
    do_iret();
    hw_entry("R7", 3072, 60, 4);
    do_iret();
    hw_entry("R7", 4096, 70, 8);
    // R10 boundary ignored while privileged
    bnd(1, 5'd4, 0, 2'd0, 16'd80, 16'd9, 3'd2);
    chk(!ent_valid && priv && new_ip == 16'd4096, "R10", "ignored in priv", int'(new_ip), 4096);
    do_iret();
    chk(!priv, "R10", "user after iret", int'(priv), 0);
    bnd(0, 5'd0, 0, 2'd0, 16'd90, 16'd2, 3'd2);
    chk(!ent_valid && !priv, "R7", "nothing left pending", int'(ent_valid), 0);

    // R6 failed push keeps disk pending and retries
    do_raise(3'b010);
    bnd(0, 5'd0, 0, 2'd0, 16'd110, 16'd31, 3'd2);
    chk(exc_valid && ecode == 2'd2 && !we && new_ip == 16'd1024, "R5", "hw push fault",
        int'(ecode), 2);
    chk(eaddr == 16'd32 && new_sp == 16'd31, "R5", "fault addr/sp", int'(eaddr), 32);
    do_iret();
    hw_entry("R6", 3072, 120, 3);
    do_iret();

    // R8 exception before pending timer
    do_raise(3'b001);
    bnd(0, 5'd0, 1, 2'd3, 16'd130, 16'd4, 3'd2);
    chk(exc_valid && ecode == 2'd3 && !we && new_ip == 16'd1024, "R8", "exception first",
        int'(ecode), 3);
    do_iret();
    hw_entry("R8", 2048, 140, 5);
    do_iret();

    // R11 software request before pending timer
    do_raise(3'b001);
    bnd(1, 5'd4, 0, 2'd0, 16'd150, 16'd6, 3'd2);
    chk(ent_valid && new_ip == 16'd5120 && mdata == 16'd152, "R11", "swi first",
        int'(new_ip), 5120);
    do_iret();
    hw_entry("R11", 2048, 160, 7);
    do_iret();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule